// File: doc/BRIEF.md
# Receive Frame Size Statistics Unit

This block sits beside a receive path and gets one report per arriving frame: the frame length without its check sequence and the length with it, plus two control bits. It decides whether the frame is too long, flags oversized frames for dropping and counts them. Accepted frames are counted into six length bins, into a total-packets counter and into a 64-bit total-octets counter. Each total is copied into a matching "good" register.

Every counter saturates at all ones instead of wrapping. Software reads the counters through a combinational 32-bit address/data port. The counter widths are parameters. The octet counter is presented as a low word and a high word.

Top module: `rx_size_stats`

## Requirements
- R1: A reported frame (`frmValid` high) whose `frmLen` exceeds 16384 is oversized when `storeBadPkt` is low, whatever `longPktEn` is.
- R2: With `longPktEn` low and `storeBadPkt` low, a frame whose `frmLen` exceeds 1522 is oversized. A frame of exactly 1522 is accepted.
- R3: With `storeBadPkt` high, no frame is oversized. Every reported frame is then accepted, and `frmDrop` stays low.
- R4: For an oversized frame, the oversize counter (address 0) increments and `frmDrop` is high for exactly the one cycle after the report edge. No bin, packet or octet register changes.
- R5: An accepted frame increments one bin chosen by `frmFcsLen`: exactly 64 → address 1; 65–127 → 2; 128–255 → 3; 256–511 → 4; 512–1023 → 5; above 1023 → 6. Below 64 no bin changes.
- R6: Each accepted frame increments the total-packets counter (address 7). The good-packets register (address 8) then equals it.
- R7: Each accepted frame adds `frmLen`+4 to the total-octets counter. Its low word is at address 9 and its high word at address 10. Copies are at 11 and 12.
- R8: The bin, packet and oversize counters stop at all ones (2^CNT_W−1) and never wrap.
- R9: The octet counter stops at all ones (2^OCT_W−1) when an addition would overflow.
- R10: After reset all readable registers are zero. Addresses 13–15 read zero, and narrow counters read zero-extended.
- R11: While `frmValid` is low no register changes and `frmDrop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | Frame report strobe, one cycle per frame |
| frmLen | input | LEN_W | Frame length in bytes without check sequence |
| frmFcsLen | input | LEN_W | Frame length in bytes including check sequence |
| longPktEn | input | 1 | Raise the size limit from 1522 to 16384 |
| storeBadPkt | input | 1 | Accept every frame regardless of size |
| frmDrop | output | 1 | One-cycle pulse: last reported frame was oversized |
| rdAddr | input | 4 | Register read address |
| rdData | output | 32 | Register read data (combinational) |

## Verification
On every cycle, the assertions check the following:
- A frame is never both dropped and counted.
- At most one bin fires per frame.
- The good-packets copy tracks the total.
- A full counter stays full.
- The octet total never falls.
- `storeBadPkt` suppresses the drop pulse.

The exact size thresholds at 1522 and 16384, the boundaries between bins, the +4 octet adjustment and the low/high split are shown only by the bench's scenarios. The same holds for saturation at the point of overflow and for zero reads of unmapped addresses. The bench compares every register against a behavioural model after each frame.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
  localparam int NUM_BINS = 6;

  typedef struct packed {
    logic                incOvr;
    logic                incPkt;
    logic [NUM_BINS-1:0] binHit;
  } rxst_strobe_t;
endpackage

// File: rtl/rxst_satcnt.sv
module rxst_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic pastValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (inc && !(&q)) q <= q + 1'b1;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && (&q)) |=> (&q)); // R8
endmodule

// File: rtl/rxst_ctrl.sv
module rxst_ctrl
  import rxst_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frmValid,
  input  logic [LEN_W-1:0] frmLen,
  input  logic [LEN_W-1:0] frmFcsLen,
  input  logic             longPktEn,
  input  logic             storeBadPkt,
  output rxst_strobe_t     strobe,
  output logic             frmDrop
);
  localparam logic [LEN_W-1:0] STD_LIM   = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] JUMBO_LIM = LEN_W'(JUMBO_MAX);
  localparam logic [LEN_W-1:0] MIN_FRM   = LEN_W'(64);
  localparam logic [LEN_W-1:0] BIG_FRM   = LEN_W'(1024);

  logic tooLong;
  logic overSize;
  logic [NUM_BINS-1:0] binRaw;

  always_comb begin
    tooLong  = (frmLen > JUMBO_LIM) || (!longPktEn && (frmLen > STD_LIM));
    overSize = tooLong && !storeBadPkt;
  end

  assign binRaw[0] = (frmFcsLen == MIN_FRM);
  assign binRaw[1] = (frmFcsLen > MIN_FRM) && (frmFcsLen < LEN_W'(128));
  generate
    for (genvar i = 2; i < NUM_BINS - 1; i++) begin : g_mid
      assign binRaw[i] = (frmFcsLen >= LEN_W'(1 << (i + 5))) &&
                         (frmFcsLen <  LEN_W'(1 << (i + 6)));
    end
  endgenerate
  assign binRaw[NUM_BINS-1] = (frmFcsLen >= BIG_FRM);

  always_comb begin
    strobe.incOvr = frmValid && overSize;
    strobe.incPkt = frmValid && !overSize;
    strobe.binHit = (frmValid && !overSize) ? binRaw : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frmDrop <= 1'b0;
    else        frmDrop <= strobe.incOvr;
  end

  AST_DROP_XOR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.incOvr && strobe.incPkt)); // R4
  AST_BIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.binHit)); // R5
  AST_SBP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && storeBadPkt) |=> !frmDrop); // R3
  AST_IDLE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !frmValid |=> !frmDrop); // R11
endmodule

// File: rtl/rxst_dpath.sv
module rxst_dpath
  import rxst_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int OCT_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxst_strobe_t      strobe,
  input  logic [LEN_W-1:0]  addLen,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData
);
  localparam int SUM_W = OCT_W + 1;

  logic [CNT_W-1:0] binCnt [NUM_BINS];
  logic [CNT_W-1:0] ovrCnt;
  logic [CNT_W-1:0] totPkts, goodPkts, pktNext;
  logic [OCT_W-1:0] totOct, goodOct, octNext;
  logic [SUM_W-1:0] octSum;
  logic [63:0]      totWide, goodWide;
  logic             pastValid;

  generate
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      rxst_satcnt #(.W(CNT_W)) u_bin (
        .clk(clk), .rst_n(rst_n), .inc(strobe.binHit[b]), .q(binCnt[b]));
    end
  endgenerate

  rxst_satcnt #(.W(CNT_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .inc(strobe.incOvr), .q(ovrCnt));

  always_comb begin
    pktNext = (&totPkts) ? totPkts : totPkts + 1'b1;
    octSum  = {1'b0, totOct} + SUM_W'(addLen) + SUM_W'(4);
    octNext = octSum[OCT_W] ? '1 : octSum[OCT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      totPkts   <= '0;
      goodPkts  <= '0;
      totOct    <= '0;
      goodOct   <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (strobe.incPkt) begin
        totPkts  <= pktNext;
        goodPkts <= pktNext;
        totOct   <= octNext;
        goodOct  <= octNext;
      end
    end
  end

  assign totWide  = 64'(totOct);
  assign goodWide = 64'(goodOct);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      4'd0:  rdData = 32'(ovrCnt);
      4'd1:  rdData = 32'(binCnt[0]);
      4'd2:  rdData = 32'(binCnt[1]);
      4'd3:  rdData = 32'(binCnt[2]);
      4'd4:  rdData = 32'(binCnt[3]);
      4'd5:  rdData = 32'(binCnt[4]);
      4'd6:  rdData = 32'(binCnt[5]);
      4'd7:  rdData = 32'(totPkts);
      4'd8:  rdData = 32'(goodPkts);
      4'd9:  rdData = totWide[31:0];
      4'd10: rdData = totWide[63:32];
      4'd11: rdData = goodWide[31:0];
      4'd12: rdData = goodWide[63:32];
      default: rdData = '0;
    endcase
  end

  AST_GOOD_PKT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (goodPkts == totPkts)); // R6
  AST_OCT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |=> (totOct >= $past(totOct))); // R9
  AST_PKT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && (&totPkts)) |=> (&totPkts)); // R8
endmodule

// File: rtl/rx_size_stats.sv
module rx_size_stats
  import rxst_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 64,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frmValid,
  input  logic [LEN_W-1:0] frmLen,
  input  logic [LEN_W-1:0] frmFcsLen,
  input  logic             longPktEn,
  input  logic             storeBadPkt,
  output logic             frmDrop,
  input  logic [3:0]       rdAddr,
  output logic [31:0]      rdData
);
  rxst_strobe_t strobe;

  rxst_ctrl #(.LEN_W(LEN_W), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frmValid(frmValid), .frmLen(frmLen),
    .frmFcsLen(frmFcsLen), .longPktEn(longPktEn), .storeBadPkt(storeBadPkt),
    .strobe(strobe), .frmDrop(frmDrop));

  rxst_dpath #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .ADDR_W(4)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addLen(frmLen),
    .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/sim_rx_size_stats.sv
`timescale 1ns/100ps
module sim_rx_size_stats;
  localparam int CNT_W = 8;
  localparam int OCT_W = 20;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;
  localparam longint OMAX = (64'd1 << OCT_W) - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        frmValid = 0;
  logic [15:0] frmLen = 0, frmFcsLen = 0;
  logic        longPktEn = 0, storeBadPkt = 0;
  logic        frmDrop;
  logic [3:0]  rdAddr = 0;
  logic [31:0] rdData;

  int checks = 0, fails = 0;
  longint model [13];
  bit expDrop = 0;

  always #4 clk = ~clk;

  rx_size_stats #(.CNT_W(CNT_W), .OCT_W(OCT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frmValid(frmValid), .frmLen(frmLen),
    .frmFcsLen(frmFcsLen), .longPktEn(longPktEn), .storeBadPkt(storeBadPkt),
    .frmDrop(frmDrop), .rdAddr(rdAddr), .rdData(rdData));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void satInc(int idx);
    if (model[idx] < CMAX) model[idx]++;
  endfunction

  // Reference model for one report
  function automatic void modelFrame(int len, int fcs, bit lpe, bit sbp);
    bit ovr = !sbp && (len > 16384 || (len > 1522 && !lpe));
    expDrop = ovr;
    if (ovr) begin
      satInc(0);
      return;
    end
    if (fcs == 64) satInc(1);
    else if (fcs > 64 && fcs <= 127) satInc(2);
    else if (fcs >= 128 && fcs <= 255) satInc(3);
    else if (fcs >= 256 && fcs <= 511) satInc(4);
    else if (fcs >= 512 && fcs <= 1023) satInc(5);
    else if (fcs > 1023) satInc(6);
    satInc(7);
    model[8] = model[7];
    begin
      longint tot = (model[10] << 32) | model[9];
      tot = tot + len + 4;
      if (tot > OMAX) tot = OMAX;
      model[9] = tot & 64'hFFFF_FFFF;
      model[10] = tot >> 32;
      model[11] = model[9];
      model[12] = model[10];
    end
  endfunction

  task automatic readAll(string req);
    for (int a = 0; a < 16; a++) begin
      rdAddr = 4'(a);
      #0.2;
      chk(req, rdData, (a < 13) ? model[a] : 0);
    end
  endtask

  // Drive at negedge, check drop and registers after the edge
  task automatic frame(int len, int fcs, bit lpe, bit sbp, string req, bit full = 1);
    @(negedge clk);
    frmLen = 16'(len); frmFcsLen = 16'(fcs);
    longPktEn = lpe; storeBadPkt = sbp; frmValid = 1;
    modelFrame(len, fcs, lpe, sbp);
    @(negedge clk);
    frmValid = 0;
    chk({req, " drop"}, frmDrop, expDrop);
    if (full) readAll(req);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 13; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    readAll("R10 reset");
    chk("R10 drop", frmDrop, 0);

    // R5 bins and boundaries
    frame(60, 64, 0, 0, "R5 exact64");
    frame(59, 63, 0, 0, "R5 below64");
    frame(61, 65, 0, 0, "R5 65");
    frame(123, 127, 0, 0, "R5 127");
    frame(124, 128, 0, 0, "R5 128");
    frame(251, 255, 0, 0, "R5 255");
    frame(252, 256, 0, 0, "R5 256");
    frame(507, 511, 0, 0, "R5 511");
    frame(508, 512, 0, 0, "R5 512");
    frame(1019, 1023, 0, 0, "R5 1023");
    frame(1020, 1024, 0, 0, "R6 R7 1024");
    // R2 standard limit
    frame(1522, 1526, 0, 0, "R2 1522 accepted");
    frame(1523, 1527, 0, 0, "R2 R4 1523 dropped");
    frame(1523, 1527, 1, 0, "R2 1523 long enabled");
    // R1 jumbo limit
    frame(16384, 16388, 1, 0, "R1 16384 accepted");
    frame(16385, 16389, 1, 0, "R1 R4 16385 dropped");
    frame(16385, 16389, 0, 0, "R1 16385 no lpe");
    // R3 store bad
    frame(20000, 20004, 0, 1, "R3 huge stored");
    frame(1600, 1604, 0, 1, "R3 mid stored");

    // R11 idle cycles with changing inputs
    @(negedge clk);
    frmLen = 16'd30000; frmFcsLen = 16'd64; longPktEn = 0; storeBadPkt = 0;
    repeat (5) begin
      @(negedge clk);
      chk("R11 idle drop", frmDrop, 0);
    end
    readAll("R11 idle");

    // R8 oversize and bin saturation
    for (int i = 0; i < 270; i++) frame(2000, 2004, 0, 0, "R8 ovr", 0);
    readAll("R8 ovr sat");
    for (int i = 0; i < 260; i++) frame(60, 64, 0, 0, "R8 bin", 0);
    readAll("R8 pkt sat");

    // R9 octet saturation
    for (int i = 0; i < 70; i++) frame(16000, 16004, 1, 0, "R9 oct", 0);
    readAll("R9 oct sat");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule